// File: doc/BRIEF.md
# Operand-Wakeup Issue Station

This block is a small pool of waiting slots in front of one execution unit in a speculative out-of-order core. An upstream issue stage offers one operation per cycle. It carries an opcode, two source operands and the reorder-buffer number assigned to the operation's result. Each source comes either as a value or as the reorder-buffer number of the operation that will produce it. The station accepts the operation only when a slot is free and the reorder buffer reports a free entry.

Waiting slots watch the common result bus. When a broadcast carries the tag a source is waiting on, the slot copies the value. Once both sources are present, the slot is a candidate for the execution unit. Among the candidates, the one allocated earliest is offered first. A slot stays held after dispatch until its own destination tag appears on the result bus, and then it is released. A flush empties every slot at once.

Each slot runs a four-state machine:
- `SL_EMPTY`: the slot is free.
- `SL_WAIT`: at least one source is still missing.
- `SL_READY`: both sources are present and the slot waits for the unit.
- `SL_EXEC`: the operation was handed to the unit and its result is not yet broadcast.

The transitions are:
- alloc: `SL_EMPTY` to `SL_WAIT`, or to `SL_READY` when both sources are already present.
- wake: `SL_WAIT` to `SL_READY`.
- dispatch: `SL_READY` to `SL_EXEC`.
- writeback: `SL_EXEC` to `SL_EMPTY`.
- flush: any state to `SL_EMPTY`.

Top module: `wake_issue_station`

## Requirements
- R1: `iss_accept` is 1 exactly when `iss_valid`=1, `rob_slot_free`=1, `flush`=0 and at least one slot is empty. When all slots are held or `rob_slot_free`=0, it is 0.
- R2: A source offered with its ready flag at 1 is stored as that value, and it reaches `exe_a`/`exe_b` unchanged. The opcode and destination tag reach `exe_op`/`exe_tag` unchanged.
- R3: A slot waiting on a source tag captures `cdb_data` in the cycle `cdb_valid`=1 with a matching `cdb_tag`.
- R4: A broadcast in the same cycle as the issue, whose tag matches a pending source, is captured for that source.
- R5: `exe_valid` is 1 only for a slot holding both sources. A slot whose sources became complete at a clock edge is offered in the cycle after that edge.
- R6: When several slots are ready, the one allocated earliest is offered on the `exe_*` outputs. A slot leaves the candidates at the edge where `exe_valid` and `fu_ready` are both 1. At most one slot leaves per cycle.
- R7: A dispatched slot becomes empty at the edge where its destination tag is broadcast with `cdb_valid`=1.
- R8: `flush`=1 empties every slot at the next edge, and no issue is accepted in that cycle. A later broadcast of a tag that a flushed slot waited on produces no dispatch.
- R9: After reset, all slots are empty and `exe_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty all slots |
| iss_valid | input | 1 | Operation offered |
| rob_slot_free | input | 1 | Reorder buffer has a free entry |
| iss_op | input | OP_W | Opcode |
| iss_dst_tag | input | TAG_W | Reorder-buffer number of the result |
| iss_a_rdy | input | 1 | Source A is a value |
| iss_a_val | input | DATA_W | Source A value |
| iss_a_tag | input | TAG_W | Source A producer tag |
| iss_b_rdy | input | 1 | Source B is a value |
| iss_b_val | input | DATA_W | Source B value |
| iss_b_tag | input | TAG_W | Source B producer tag |
| iss_accept | output | 1 | Operation taken this cycle |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Broadcast tag |
| cdb_data | input | DATA_W | Broadcast value |
| fu_ready | input | 1 | Execution unit takes an operation |
| exe_valid | output | 1 | Operation offered to the unit |
| exe_op | output | OP_W | Offered opcode |
| exe_a | output | DATA_W | Offered source A |
| exe_b | output | DATA_W | Offered source B |
| exe_tag | output | TAG_W | Offered destination tag |

## Verification
The hardest case to reach from the ports is the age order diverging from slot order. This needs a younger operation sitting in a lower-numbered slot while an older one is also ready. The stimulus first dispatches an operation from slot 0 while holding a second in slot 1. It then frees slot 0 by broadcasting the first operation's tag and refills slot 0, with the unit stalled until both are ready. Two further timing races are produced directly by driving issue and broadcast, or flush and issue, in the same cycle.

// File: rtl/station_pkg.sv
package station_pkg;

    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_WAIT  = 2'd1,
        SL_READY = 2'd2,
        SL_EXEC  = 2'd3
    } slot_state_e;

endpackage

// File: rtl/station_slot.sv
module station_slot
    import station_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic              in_a_rdy,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic              in_b_rdy,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              take,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   out_op,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic [TAG_W-1:0]  out_dst
);

    slot_state_e st_q, st_d;

    logic              a_have_q, b_have_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q, dst_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;
    logic [OP_W-1:0]   op_q;

    logic a_hit, b_hit, ia_hit, ib_hit, ia_have, ib_have, wb_hit;

    // snoop of the result bus for a held slot
    assign a_hit  = cdb_valid && !a_have_q && (cdb_tag == a_tag_q);
    assign b_hit  = cdb_valid && !b_have_q && (cdb_tag == b_tag_q);
    // snoop at allocation, so a broadcast in the issue cycle is kept
    assign ia_hit = cdb_valid && !in_a_rdy && (cdb_tag == in_a_tag);
    assign ib_hit = cdb_valid && !in_b_rdy && (cdb_tag == in_b_tag);
    assign ia_have = in_a_rdy || ia_hit;
    assign ib_have = in_b_rdy || ib_hit;
    assign wb_hit = cdb_valid && (cdb_tag == dst_q);

    // next state
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = SL_EMPTY;
        end else begin
            unique case (st_q)
                SL_EMPTY: if (alloc) st_d = (ia_have && ib_have) ? SL_READY : SL_WAIT;
                SL_WAIT:  if ((a_have_q || a_hit) && (b_have_q || b_hit)) st_d = SL_READY;
                SL_READY: if (take) st_d = SL_EXEC;
                SL_EXEC:  if (wb_hit) st_d = SL_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SL_EMPTY;
        else        st_q <= st_d;
    end

    // payload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_have_q <= 1'b0;
            b_have_q <= 1'b0;
            a_tag_q  <= '0;
            b_tag_q  <= '0;
            a_val_q  <= '0;
            b_val_q  <= '0;
            dst_q    <= '0;
            op_q     <= '0;
        end else if (alloc && !flush) begin
            op_q     <= in_op;
            dst_q    <= in_dst;
            a_tag_q  <= in_a_tag;
            b_tag_q  <= in_b_tag;
            a_have_q <= ia_have;
            b_have_q <= ib_have;
            a_val_q  <= in_a_rdy ? in_a_val : cdb_data;
            b_val_q  <= in_b_rdy ? in_b_val : cdb_data;
        end else if (st_q == SL_WAIT) begin
            if (a_hit) begin
                a_have_q <= 1'b1;
                a_val_q  <= cdb_data;
            end
            if (b_hit) begin
                b_have_q <= 1'b1;
                b_val_q  <= cdb_data;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (st_q != SL_EMPTY);
        ready   = (st_q == SL_READY);
        out_op  = op_q;
        out_a   = a_val_q;
        out_b   = b_val_q;
        out_dst = dst_q;
    end

    // R1: allocation only lands on an empty slot
    p_alloc_into_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (st_q == SL_EMPTY));

    // R5: a slot is handed out only with both sources held
    p_take_only_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (st_q == SL_READY && a_have_q && b_have_q));

    // R3: the last missing source arriving wakes the slot
    p_wake_on_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_WAIT && !flush && (a_have_q || a_hit) && (b_have_q || b_hit))
        |=> (st_q == SL_READY));

    // R7: own result broadcast releases a dispatched slot
    p_free_on_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_EXEC && wb_hit && !flush) |=> (st_q == SL_EMPTY));

endmodule

// File: rtl/age_picker.sv
module age_picker #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc,
    input  logic [N-1:0] rdy,
    output logic [N-1:0] grant
);

    // older_q[i][j] = 1 : slot i was allocated before slot j
    logic [N-1:0] older_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc[i])
                        older_q[i][j] <= 1'b0;
                    else if (alloc[j] && (i != j))
                        older_q[i][j] <= 1'b1;
                end
            end
        end
    end

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_pick
            always_comb begin
                grant[gi] = rdy[gi];
                for (int j = 0; j < N; j++) begin
                    if ((j != gi) && rdy[j] && !older_q[gi][j])
                        grant[gi] = 1'b0;
                end
            end
        end
    endgenerate

    // R6: one winner at most, and only among ready slots
    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~rdy) == '0);
    p_some_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy != '0) |-> (grant != '0));

endmodule

// File: rtl/wake_issue_station.sv
module wake_issue_station
    import station_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic              rob_slot_free,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_dst_tag,
    input  logic              iss_a_rdy,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic              iss_b_rdy,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    output logic              iss_accept,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              fu_ready,
    output logic              exe_valid,
    output logic [OP_W-1:0]   exe_op,
    output logic [DATA_W-1:0] exe_a,
    output logic [DATA_W-1:0] exe_b,
    output logic [TAG_W-1:0]  exe_tag
);

    localparam logic [SLOTS-1:0] ALL_BUSY = {SLOTS{1'b1}};

    logic [SLOTS-1:0] busy, rdy, grant, alloc_vec, take_vec;
    logic [OP_W-1:0]   s_op  [SLOTS];
    logic [DATA_W-1:0] s_a   [SLOTS];
    logic [DATA_W-1:0] s_b   [SLOTS];
    logic [TAG_W-1:0]  s_dst [SLOTS];

    // lowest empty slot takes the next operation
    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_vec = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!busy[i] && !found) begin
                found        = 1'b1;
                alloc_vec[i] = iss_accept;
            end
        end
    end

    assign iss_accept = iss_valid && rob_slot_free && !flush && (busy != ALL_BUSY);
    assign take_vec   = grant & {SLOTS{fu_ready}};

    generate
        for (genvar gs = 0; gs < SLOTS; gs++) begin : g_slot
            station_slot #(
                .OP_W   (OP_W),
                .TAG_W  (TAG_W),
                .DATA_W (DATA_W)
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .flush     (flush),
                .alloc     (alloc_vec[gs]),
                .in_op     (iss_op),
                .in_dst    (iss_dst_tag),
                .in_a_rdy  (iss_a_rdy),
                .in_a_val  (iss_a_val),
                .in_a_tag  (iss_a_tag),
                .in_b_rdy  (iss_b_rdy),
                .in_b_val  (iss_b_val),
                .in_b_tag  (iss_b_tag),
                .cdb_valid (cdb_valid),
                .cdb_tag   (cdb_tag),
                .cdb_data  (cdb_data),
                .take      (take_vec[gs]),
                .busy      (busy[gs]),
                .ready     (rdy[gs]),
                .out_op    (s_op[gs]),
                .out_a     (s_a[gs]),
                .out_b     (s_b[gs]),
                .out_dst   (s_dst[gs])
            );
        end
    endgenerate

    age_picker #(.N(SLOTS)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc_vec),
        .rdy   (rdy),
        .grant (grant)
    );

    // one-hot output mux
    always_comb begin
        exe_valid = |grant;
        exe_op    = '0;
        exe_a     = '0;
        exe_b     = '0;
        exe_tag   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (grant[i]) begin
                exe_op  = exe_op  | s_op[i];
                exe_a   = exe_a   | s_a[i];
                exe_b   = exe_b   | s_b[i];
                exe_tag = exe_tag | s_dst[i];
            end
        end
    end

    // R8: flush leaves every slot empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy == '0));

    // R6: at most one slot leaves per cycle
    p_one_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(take_vec) <= 1);

    // R1: no more than one slot is filled per cycle
    p_one_alloc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec));

endmodule

// File: tb/sim_wake_issue_station.sv
`timescale 1ns/1ps
module sim_wake_issue_station;

    localparam int SLOTS = 4, OP_W = 4, TAG_W = 3, DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n, flush, iss_valid, rob_slot_free, iss_a_rdy, iss_b_rdy;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_dst_tag, iss_a_tag, iss_b_tag, cdb_tag;
    logic [DATA_W-1:0] iss_a_val, iss_b_val, cdb_data;
    logic cdb_valid, fu_ready, iss_accept, exe_valid;
    logic [OP_W-1:0]   exe_op;
    logic [DATA_W-1:0] exe_a, exe_b;
    logic [TAG_W-1:0]  exe_tag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wake_issue_station #(.SLOTS(SLOTS), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
        .rob_slot_free(rob_slot_free), .iss_op(iss_op), .iss_dst_tag(iss_dst_tag),
        .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
        .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
        .iss_accept(iss_accept), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_data(cdb_data), .fu_ready(fu_ready), .exe_valid(exe_valid),
        .exe_op(exe_op), .exe_a(exe_a), .exe_b(exe_b), .exe_tag(exe_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic idle_inputs();
        flush = 0; iss_valid = 0; rob_slot_free = 1; iss_op = '0; iss_dst_tag = '0;
        iss_a_rdy = 1; iss_a_val = '0; iss_a_tag = '0;
        iss_b_rdy = 1; iss_b_val = '0; iss_b_tag = '0;
        cdb_valid = 0; cdb_tag = '0; cdb_data = '0;
    endtask

    // drive an issue at the current negedge (held for one cycle by caller)
    task automatic put_issue(input int op, input int dst, input bit ar, input int av,
                             input int at, input bit br, input int bv, input int bt);
        iss_valid = 1; iss_op = OP_W'(op); iss_dst_tag = TAG_W'(dst);
        iss_a_rdy = ar; iss_a_val = DATA_W'(av); iss_a_tag = TAG_W'(at);
        iss_b_rdy = br; iss_b_val = DATA_W'(bv); iss_b_tag = TAG_W'(bt);
    endtask

    task automatic do_flush();
        @(negedge clk); idle_inputs(); flush = 1;
        @(negedge clk); flush = 0;
    endtask

    task automatic t_reset();
        #1;
        chk_eq("R9 exe_valid after reset", exe_valid, 0);
        iss_valid = 1; #1;
        chk_eq("R9 empty after reset accepts", iss_accept, 1);
        iss_valid = 0;
    endtask

    task automatic t_ready_issue();
        do_flush(); fu_ready = 0;
        put_issue(5, 2, 1, 'h1111, 0, 1, 'h2222, 0); #1;
        chk_eq("R1 accept with room", iss_accept, 1);
        @(negedge clk); idle_inputs();
        chk_eq("R5 ready issue offered", exe_valid, 1);
        chk_eq("R2 op", exe_op, 5);
        chk_eq("R2 a", exe_a, 'h1111);
        chk_eq("R2 b", exe_b, 'h2222);
        chk_eq("R2 tag", exe_tag, 2);
    endtask

    task automatic t_wakeup();
        do_flush(); fu_ready = 1;
        put_issue(3, 1, 0, 0, 4, 1, 7, 0);
        @(negedge clk); idle_inputs();
        chk_eq("R5 not offered with missing source", exe_valid, 0);
        cdb_valid = 1; cdb_tag = 3'd4; cdb_data = 16'h0055;
        @(negedge clk); idle_inputs();
        chk_eq("R3 woken slot offered", exe_valid, 1);
        chk_eq("R3 captured value", exe_a, 'h55);
        chk_eq("R2 ready source kept", exe_b, 7);
        @(negedge clk);
        chk_eq("R6 dispatched slot leaves candidates", exe_valid, 0);
    endtask

    task automatic t_same_cycle();
        do_flush(); fu_ready = 0;
        put_issue(2, 4, 0, 0, 3, 1, 9, 0);
        cdb_valid = 1; cdb_tag = 3'd3; cdb_data = 16'hABCD;
        @(negedge clk); idle_inputs();
        chk_eq("R4 same-cycle capture ready", exe_valid, 1);
        chk_eq("R4 same-cycle value", exe_a, 'hABCD);
    endtask

    task automatic t_age();
        do_flush(); fu_ready = 1;
        put_issue(1, 1, 1, 'h10, 0, 1, 'h11, 0);           // P -> slot0
        @(negedge clk); idle_inputs();
        chk_eq("R6 first op offered", exe_tag, 1);
        put_issue(2, 2, 1, 'h20, 0, 1, 'h21, 0);           // Q -> slot1, P dispatched
        @(negedge clk); idle_inputs();
        fu_ready = 0;
        cdb_valid = 1; cdb_tag = 3'd1; cdb_data = 16'h0;   // P written back, slot0 freed
        @(negedge clk); idle_inputs();
        chk_eq("R7 slot0 freed, Q offered", exe_tag, 2);
        put_issue(3, 3, 1, 'h30, 0, 1, 'h31, 0);           // R -> slot0 (younger)
        @(negedge clk); idle_inputs();
        chk_eq("R6 older Q first despite higher slot", exe_tag, 2);
        fu_ready = 1;
        @(negedge clk);
        chk_eq("R6 younger R next", exe_tag, 3);
        chk_eq("R6 younger R valid", exe_valid, 1);
    endtask

    task automatic t_full_free();
        do_flush(); fu_ready = 0;
        for (int k = 0; k < SLOTS; k++) begin
            put_issue(k, k, 0, 0, 7, 1, k, 0);
            @(negedge clk); idle_inputs();
        end
        iss_valid = 1; #1;
        chk_eq("R1 full blocks accept", iss_accept, 0);
        iss_valid = 0;
        cdb_valid = 1; cdb_tag = 3'd7; cdb_data = 16'h0077;
        @(negedge clk); idle_inputs();
        chk_eq("R6 oldest of full set offered", exe_tag, 0);
        fu_ready = 1;
        @(negedge clk); fu_ready = 0;
        chk_eq("R6 one dispatch per cycle", exe_tag, 1);
        iss_valid = 1; #1;
        chk_eq("R7 dispatched slot still held", iss_accept, 0);
        iss_valid = 0;
        cdb_valid = 1; cdb_tag = 3'd0; cdb_data = 16'h0;
        @(negedge clk); idle_inputs();
        iss_valid = 1; #1;
        chk_eq("R7 writeback frees slot", iss_accept, 1);
        iss_valid = 0;
    endtask

    task automatic t_rob_block();
        do_flush();
        iss_valid = 1; rob_slot_free = 0; #1;
        chk_eq("R1 no rob entry blocks accept", iss_accept, 0);
        @(negedge clk); idle_inputs();
        chk_eq("R1 blocked issue not stored", exe_valid, 0);
    endtask

    task automatic t_flush();
        do_flush(); fu_ready = 1;
        put_issue(6, 5, 0, 0, 6, 1, 1, 0);
        @(negedge clk); idle_inputs();
        flush = 1; put_issue(6, 2, 1, 1, 0, 1, 1, 0); #1;
        chk_eq("R8 no accept during flush", iss_accept, 0);
        @(negedge clk); idle_inputs();
        cdb_valid = 1; cdb_tag = 3'd6; cdb_data = 16'h0066;
        @(negedge clk); idle_inputs();
        chk_eq("R8 flushed slot not revived", exe_valid, 0);
        iss_valid = 1; #1;
        chk_eq("R8 room after flush", iss_accept, 1);
        iss_valid = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs(); fu_ready = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_ready_issue();
        t_wakeup();
        t_same_cycle();
        t_age();
        t_full_free();
        t_rob_block();
        t_flush();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule